// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block holds the interrupt state of one processor for 256 vectors. Each vector has three state bits: a pending-request bit, an in-service bit and a level-trigger bit. Incoming fixed or lowest-priority requests arrive as a vector plus a level/edge flag. The block derives the processor priority from a software-written task priority and the highest in-service vector. It offers the best pending vector to the core when that vector outranks the work already in service.

The core acknowledges the offered vector, which moves it from pending to in service. It then signals end-of-interrupt, which retires the highest in-service vector. When the retired vector was level-triggered, the block raises a one-cycle broadcast strobe carrying that vector, so that upstream interrupt sources can re-sample their lines. Comparisons use only the priority class, which is the upper four bits of a vector.

Top module: `vec_prio_tracker`

## Requirements
- R1: After reset all pending, in-service and level-trigger bits are clear, the task priority is 0, the processor priority is 0, nothing is offered and no broadcast strobe is active.
- R2: A request taken while the controller is enabled sets the pending bit of its vector, and this is visible at the outputs in the cycle after the clock edge that took it.
- R3: A level request that is taken also sets the vector's level-trigger bit.
- R4: A level request whose vector already has its pending bit set is dropped, so its level-trigger bit is not set by it.
- R5: Requests presented while enable_i is low change no state.
- R6: Processor priority uses the highest in-service vector, or 0 when none is in service. If the task priority's class (bits 7:4) is greater than or equal to that vector's class, the processor priority equals the 8-bit task priority. Otherwise it equals that vector with bits 3:0 cleared.
- R7: pend_valid_o is high only when enable_i is high and the class of the highest pending vector is strictly greater than the class of the highest in-service vector (0 when none). pend_vec_o then carries that highest pending vector, and is 0 otherwise.
- R8: An acknowledge sets the in-service bit of ack_vec_i and clears its pending bit.
- R9: An end-of-interrupt clears the highest in-service bit. If that vector's level-trigger bit is set, the block clears that bit and drives eoi_bcast_o high for exactly the next cycle, with the vector on eoi_bcast_vec_o. eoi_bcast_vec_o is 0 when no strobe is active.
- R10: An end-of-interrupt with no in-service bit set has no effect and raises no strobe.
- R11: A task-priority write keeps only bits 7:0 of tpr_wdata_i, and the stored value appears on tpr_o after the edge.
- R12: When an acknowledge and a request name the same vector in one cycle, the acknowledge is applied first and the request then sets the pending bit again. A level request in that case is not treated as a repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Controller enabled |
| req_valid_i | input | 1 | Incoming fixed or lowest-priority request |
| req_vec_i | input | 8 | Requested vector |
| req_level_i | input | 1 | 1 for level-triggered, 0 for edge |
| ack_i | input | 1 | Core acknowledges a vector |
| ack_vec_i | input | 8 | Vector being acknowledged |
| eoi_i | input | 1 | End-of-interrupt |
| tpr_we_i | input | 1 | Task-priority write strobe |
| tpr_wdata_i | input | 32 | Task-priority write data |
| tpr_o | output | 8 | Stored task priority |
| ppr_o | output | 8 | Processor priority |
| pend_valid_o | output | 1 | A deliverable vector is offered |
| pend_vec_o | output | 8 | Offered vector |
| eoi_bcast_o | output | 1 | Level end-of-interrupt broadcast strobe |
| eoi_bcast_vec_o | output | 8 | Vector of the broadcast |

## Verification
The assertions assume that every control input holds a known value after reset, and that ack_vec_i is meaningful whenever ack_i is high. The acknowledge property excludes only the same-vector request collision, which R12 defines separately. The stimulus drives all inputs on the falling edge. It mostly acknowledges the currently offered vector, but sometimes acknowledges an arbitrary vector, so that in-service bits can sit above pending ones. It also toggles the enable rarely and mixes task-priority writes, so that every branch of the priority compare is reached.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned NUM_VEC = 1 << VEC_W;
  localparam int unsigned CLS_W   = 4;

  typedef logic [VEC_W-1:0] vec_t;

  typedef struct packed {
    logic valid;
    vec_t vec;
  } vec_hit_t;
endpackage

// File: rtl/vpt_prio_enc.sv
// Highest-set-bit search: per-group local encode, then pick highest live group.
module vpt_prio_enc #(
  parameter int unsigned WIDTH = 256,
  parameter int unsigned GRP_W = 32
) (
  input  logic [WIDTH-1:0]         bits_i,
  output logic                     valid_o,
  output logic [$clog2(WIDTH)-1:0] idx_o
);
  localparam int unsigned NGRP  = WIDTH / GRP_W;
  localparam int unsigned GIW   = $clog2(GRP_W);
  localparam int unsigned NGW   = $clog2(NGRP);

  logic [NGRP-1:0]          grp_any;
  logic [NGRP-1:0][GIW-1:0] grp_loc;
  logic [NGW-1:0]           grp_sel;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP_W-1:0] slice;
    logic [GIW-1:0]   loc_w;
    assign slice = bits_i[g*GRP_W +: GRP_W];
    always_comb begin
      loc_w = '0;
      for (int i = 0; i < GRP_W; i++)
        if (slice[i]) loc_w = GIW'(i);
    end
    assign grp_any[g] = |slice;
    assign grp_loc[g] = loc_w;
  end

  always_comb begin
    grp_sel = '0;
    for (int k = 0; k < NGRP; k++)
      if (grp_any[k]) grp_sel = NGW'(k);
  end

  assign valid_o = |grp_any;
  assign idx_o   = valid_o ? {grp_sel, grp_loc[grp_sel]} : '0;
endmodule

// File: rtl/vpt_vec_arrays.sv
// Pending / in-service / level-trigger state. Order within a cycle:
// retire (eoi), then acknowledge, then new request.
module vpt_vec_arrays
  import vpt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               req_valid_i,
  input  vec_t               req_vec_i,
  input  logic               req_level_i,
  input  logic               ack_i,
  input  vec_t               ack_vec_i,
  input  logic               eoi_i,
  input  logic               isr_valid_i,
  input  vec_t               isr_top_i,
  output logic [NUM_VEC-1:0] irr_o,
  output logic [NUM_VEC-1:0] isr_o,
  output logic [NUM_VEC-1:0] tmr_o,
  output logic               bcast_o,
  output vec_t               bcast_vec_o
);
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
  logic               bc_q, bc_n;
  vec_t               bcv_q, bcv_n;

  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    bc_n  = 1'b0;
    bcv_n = '0;
    if (eoi_i && isr_valid_i) begin
      isr_n[isr_top_i] = 1'b0;
      if (tmr_q[isr_top_i]) begin
        tmr_n[isr_top_i] = 1'b0;
        bc_n  = 1'b1;
        bcv_n = isr_top_i;
      end
    end
    if (ack_i) begin
      isr_n[ack_vec_i] = 1'b1;
      irr_n[ack_vec_i] = 1'b0;
    end
    if (req_valid_i && enable_i) begin
      if (!(req_level_i && irr_n[req_vec_i])) begin
        irr_n[req_vec_i] = 1'b1;
        if (req_level_i) tmr_n[req_vec_i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
      bc_q  <= 1'b0;
      bcv_q <= '0;
    end else begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      tmr_q <= tmr_n;
      bc_q  <= bc_n;
      bcv_q <= bcv_n;
    end
  end

  assign irr_o       = irr_q;
  assign isr_o       = isr_q;
  assign tmr_o       = tmr_q;
  assign bcast_o     = bc_q;
  assign bcast_vec_o = bcv_q;
endmodule

// File: rtl/vpt_prio_calc.sv
// Class compares for processor priority and deliverability.
module vpt_prio_calc
  import vpt_pkg::*;
(
  input  logic enable_i,
  input  vec_t tpr_i,
  input  logic isr_valid_i,
  input  vec_t isr_top_i,
  input  logic irr_valid_i,
  input  vec_t irr_top_i,
  output vec_t ppr_o,
  output logic pend_valid_o,
  output vec_t pend_vec_o
);
  localparam int unsigned LO_W = VEC_W - CLS_W;

  vec_t              isr_eff;
  logic [CLS_W-1:0]  isr_cls, tpr_cls, irr_cls;

  assign isr_eff = isr_valid_i ? isr_top_i : '0;
  assign isr_cls = isr_eff[VEC_W-1 -: CLS_W];
  assign tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
  assign irr_cls = irr_top_i[VEC_W-1 -: CLS_W];

  assign ppr_o        = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {LO_W{1'b0}}};
  assign pend_valid_o = enable_i && irr_valid_i && (irr_cls > isr_cls);
  assign pend_vec_o   = pend_valid_o ? irr_top_i : '0;
endmodule

// File: rtl/vec_prio_tracker.sv
module vec_prio_tracker
  import vpt_pkg::*;
#(
  parameter int unsigned GRP_W = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic        req_valid_i,
  input  logic [7:0]  req_vec_i,
  input  logic        req_level_i,
  input  logic        ack_i,
  input  logic [7:0]  ack_vec_i,
  input  logic        eoi_i,
  input  logic        tpr_we_i,
  input  logic [31:0] tpr_wdata_i,
  output logic [7:0]  tpr_o,
  output logic [7:0]  ppr_o,
  output logic        pend_valid_o,
  output logic [7:0]  pend_vec_o,
  output logic        eoi_bcast_o,
  output logic [7:0]  eoi_bcast_vec_o
);
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  vec_hit_t           irr_hit, isr_hit;
  vec_t               tpr_q;

  vpt_prio_enc #(.WIDTH(NUM_VEC), .GRP_W(GRP_W)) u_irr_enc (
    .bits_i (irr_q),
    .valid_o(irr_hit.valid),
    .idx_o  (irr_hit.vec)
  );

  vpt_prio_enc #(.WIDTH(NUM_VEC), .GRP_W(GRP_W)) u_isr_enc (
    .bits_i (isr_q),
    .valid_o(isr_hit.valid),
    .idx_o  (isr_hit.vec)
  );

  vpt_vec_arrays u_arr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .req_valid_i(req_valid_i),
    .req_vec_i  (req_vec_i),
    .req_level_i(req_level_i),
    .ack_i      (ack_i),
    .ack_vec_i  (ack_vec_i),
    .eoi_i      (eoi_i),
    .isr_valid_i(isr_hit.valid),
    .isr_top_i  (isr_hit.vec),
    .irr_o      (irr_q),
    .isr_o      (isr_q),
    .tmr_o      (tmr_q),
    .bcast_o    (eoi_bcast_o),
    .bcast_vec_o(eoi_bcast_vec_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tpr_q <= '0;
    else if (tpr_we_i) tpr_q <= tpr_wdata_i[VEC_W-1:0];
  end

  vpt_prio_calc u_calc (
    .enable_i    (enable_i),
    .tpr_i       (tpr_q),
    .isr_valid_i (isr_hit.valid),
    .isr_top_i   (isr_hit.vec),
    .irr_valid_i (irr_hit.valid),
    .irr_top_i   (irr_hit.vec),
    .ppr_o       (ppr_o),
    .pend_valid_o(pend_valid_o),
    .pend_vec_o  (pend_vec_o)
  );

  assign tpr_o = tpr_q;
endmodule

// File: rtl/vpt_checker.sv
module vpt_checker (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         enable_i,
  input logic         req_valid_i,
  input logic [7:0]   req_vec_i,
  input logic         ack_i,
  input logic [7:0]   ack_vec_i,
  input logic         eoi_i,
  input logic         tpr_we_i,
  input logic [31:0]  tpr_wdata_i,
  input logic [7:0]   tpr_o,
  input logic [7:0]   ppr_o,
  input logic         pend_valid_o,
  input logic [7:0]   pend_vec_o,
  input logic         eoi_bcast_o,
  input logic [255:0] irr_q,
  input logic [255:0] isr_q,
  input logic         isr_valid,
  input logic [7:0]   isr_top
);
  logic [7:0] ack_vec_d;
  logic       ack_chk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_vec_d <= '0;
      ack_chk_d <= 1'b0;
    end else begin
      ack_vec_d <= ack_vec_i;
      ack_chk_d <= ack_i && !(req_valid_i && enable_i && req_vec_i == ack_vec_i);
    end
  end

  // R8
  a_r8_ack_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_chk_d |-> (isr_q[ack_vec_d] && !irr_q[ack_vec_d]));

  a_r5_disabled_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && req_valid_i && !ack_i) |=> (irr_q == $past(irr_q)));

  a_r6_ppr_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o >= tpr_o);

  a_r7_offer_outranks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> (enable_i && (pend_vec_o[7:4] > (isr_valid ? isr_top[7:4] : 4'd0))));

  a_r9_strobe_follows_eoi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bcast_o |-> $past(eoi_i));

  a_r10_empty_eoi_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !isr_valid) |=> !eoi_bcast_o);

  a_r11_tpr_low_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpr_we_i |=> (tpr_o == $past(tpr_wdata_i[7:0])));
endmodule

bind vec_prio_tracker vpt_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .req_valid_i (req_valid_i),
  .req_vec_i   (req_vec_i),
  .ack_i       (ack_i),
  .ack_vec_i   (ack_vec_i),
  .eoi_i       (eoi_i),
  .tpr_we_i    (tpr_we_i),
  .tpr_wdata_i (tpr_wdata_i),
  .tpr_o       (tpr_o),
  .ppr_o       (ppr_o),
  .pend_valid_o(pend_valid_o),
  .pend_vec_o  (pend_vec_o),
  .eoi_bcast_o (eoi_bcast_o),
  .irr_q       (irr_q),
  .isr_q       (isr_q),
  .isr_valid   (isr_hit.valid),
  .isr_top     (isr_hit.vec)
);

// File: tb/vec_prio_tracker_test.sv
`timescale 1ns/1ps
module vec_prio_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        rv = 1'b0, rl = 1'b0, ak = 1'b0, eo = 1'b0, twe = 1'b0;
  logic [7:0]  rvec = '0, avec = '0;
  logic [31:0] twd = '0;
  logic [7:0]  tpr_o, ppr_o, pend_vec_o, bc_vec_o;
  logic        pend_valid_o, bc_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference state
  bit [255:0] m_irr, m_isr, m_tmr;
  bit [7:0]   m_tpr;
  bit         m_bc;
  bit [7:0]   m_bcv;

  always #2.5 clk = ~clk;

  vec_prio_tracker uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en),
    .req_valid_i(rv), .req_vec_i(rvec), .req_level_i(rl),
    .ack_i(ak), .ack_vec_i(avec), .eoi_i(eo),
    .tpr_we_i(twe), .tpr_wdata_i(twd),
    .tpr_o(tpr_o), .ppr_o(ppr_o), .pend_valid_o(pend_valid_o),
    .pend_vec_o(pend_vec_o), .eoi_bcast_o(bc_o), .eoi_bcast_vec_o(bc_vec_o)
  );

  function automatic bit [8:0] top_of(bit [255:0] a);
    for (int i = 255; i >= 0; i--)
      if (a[i]) return {1'b1, 8'(i)};
    return 9'd0;
  endfunction

  function automatic bit [7:0] exp_ppr();
    bit [8:0] t = top_of(m_isr);
    bit [7:0] iv = t[8] ? t[7:0] : 8'd0;
    return (m_tpr[7:4] >= iv[7:4]) ? m_tpr : {iv[7:4], 4'd0};
  endfunction

  function automatic bit [8:0] exp_pend();
    bit [8:0] ti = top_of(m_isr);
    bit [8:0] tr = top_of(m_irr);
    bit [7:0] iv = ti[8] ? ti[7:0] : 8'd0;
    if (en && tr[8] && tr[7:4] > iv[7:4]) return tr;
    return 9'd0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    bit [8:0] p = exp_pend();
    chk(tag, "tpr", tpr_o, m_tpr);
    chk(tag, "ppr", ppr_o, exp_ppr());
    chk(tag, "pend_valid", pend_valid_o, p[8]);
    chk(tag, "pend_vec", pend_vec_o, p[7:0]);
    chk(tag, "bcast", bc_o, m_bc);
    chk(tag, "bcast_vec", bc_vec_o, m_bcv);
  endtask

  task automatic step(string tag, bit e, bit r, bit [7:0] v, bit l,
                      bit a, bit [7:0] av, bit eoi, bit w, bit [31:0] wd);
    bit [8:0] ti;
    @(negedge clk);
    en = e; rv = r; rvec = v; rl = l; ak = a; avec = av; eo = eoi; twe = w; twd = wd;
    ti = top_of(m_isr);
    m_bc = 1'b0; m_bcv = 8'd0;
    if (eoi && ti[8]) begin
      m_isr[ti[7:0]] = 1'b0;
      if (m_tmr[ti[7:0]]) begin
        m_tmr[ti[7:0]] = 1'b0; m_bc = 1'b1; m_bcv = ti[7:0];
      end
    end
    if (a) begin m_isr[av] = 1'b1; m_irr[av] = 1'b0; end
    if (r && e && !(l && m_irr[v])) begin
      m_irr[v] = 1'b1;
      if (l) m_tmr[v] = 1'b1;
    end
    if (w) m_tpr = wd[7:0];
    @(posedge clk);
    #1;
    cmp_all(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit [8:0] p;
    void'($urandom(32'd20250611));
    m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0; m_bc = 0; m_bcv = 0;
    repeat (3) @(posedge clk);
    #1;
    cmp_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    cmp_all("R1");

    step("R2",  1, 1, 8'h45, 0, 0, 0, 0, 0, 0);
    chk("R2", "offer 45", pend_vec_o, 8'h45);
    step("R7",  1, 1, 8'h30, 0, 0, 0, 0, 0, 0);
    chk("R7", "highest kept", pend_vec_o, 8'h45);
    step("R8",  1, 0, 0, 0, 1, 8'h45, 0, 0, 0);
    chk("R6", "ppr from isr", ppr_o, 8'h40);
    chk("R7", "lower class withheld", pend_valid_o, 0);
    step("R3",  1, 1, 8'h4A, 1, 0, 0, 0, 0, 0);
    chk("R7", "equal class withheld", pend_valid_o, 0);
    step("R11", 1, 0, 0, 0, 0, 0, 0, 1, 32'hABCD_1250);
    chk("R11", "low byte", tpr_o, 8'h50);
    chk("R6", "ppr=tpr", ppr_o, 8'h50);
    step("R11", 1, 0, 0, 0, 0, 0, 0, 1, 32'h0000_003F);
    chk("R6", "isr class wins", ppr_o, 8'h40);
    step("R9",  1, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R9", "edge eoi no strobe", bc_o, 0);
    chk("R7", "offer 4A", pend_vec_o, 8'h4A);
    step("R8",  1, 0, 0, 0, 1, 8'h4A, 0, 0, 0);
    step("R9",  1, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R9", "level strobe", bc_o, 1);
    chk("R9", "level strobe vec", bc_vec_o, 8'h4A);
    step("R10", 1, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R9", "strobe one cycle", bc_o, 0);
    chk("R10", "empty eoi", ppr_o, 8'h3F);
    step("R5",  0, 1, 8'h90, 0, 0, 0, 0, 0, 0);
    chk("R7", "disabled no offer", pend_valid_o, 0);
    step("R5",  1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5", "discarded", pend_vec_o, 8'h30);
    step("R4",  1, 1, 8'h70, 0, 0, 0, 0, 0, 0);
    step("R4",  1, 1, 8'h70, 1, 0, 0, 0, 0, 0);
    step("R4",  1, 0, 0, 0, 1, 8'h70, 0, 0, 0);
    step("R4",  1, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R4", "dropped level no strobe", bc_o, 0);
    step("R12", 1, 1, 8'h80, 0, 0, 0, 0, 0, 0);
    step("R12", 1, 1, 8'h80, 1, 1, 8'h80, 0, 0, 0);
    chk("R12", "equal class withheld", pend_valid_o, 0);
    step("R12", 1, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R12", "level kept strobe", bc_o, 1);
    chk("R12", "re-set pending", pend_vec_o, 8'h80);

    for (int n = 0; n < 4000; n++) begin
      bit e, r, l, a, eoi, w;
      bit [7:0] v, av;
      e   = ($urandom % 64 == 0) ? ~en : en;
      r   = ($urandom % 3 == 0);
      v   = 8'($urandom);
      l   = $urandom % 2;
      p   = exp_pend();
      a   = p[8] ? ($urandom % 3 == 0) : ($urandom % 40 == 0);
      av  = (p[8] && ($urandom % 8 != 0)) ? p[7:0] : 8'($urandom);
      eoi = ($urandom % 5 == 0);
      w   = ($urandom % 16 == 0);
      step("R2R7", e, r, v, l, a, av, eoi, w, $urandom);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule